// File: doc/BRIEF.md
# DS3 Path Data-Link Message Transmitter

This block sends one path maintenance message at a time over the data-link overhead bits of an outbound DS3 signal. The message is built as a bit-oriented HDLC frame. The framer that owns the line gives the block a single-cycle strobe each time a data-link bit position passes. In a DS3 M-frame there are only three such positions, all in subframe 5. On each strobe the block presents one bit, and its sequence advances at that clock edge.

A host fills an 88-byte local buffer with the message. The buffer holds the address and control octets followed by the information field. The host then picks the short (76-byte) or the long (82-byte) length and pulses start. The block waits for the idle flag in progress to finish and then sends the frame in this order: an opening flag, the buffer bytes in address order, a 16-bit frame check sequence, and a closing flag. Zero-bit insertion applies between the two flags. When no frame is pending, the line carries a continuous stream of flags. A one-cycle done pulse marks the end of the closing flag. A busy output guards the buffer while a frame is in flight.

Top module: `dl_msg_tx`

## Requirements
- R1: After reset, dl_bit is 0 (bit 0 of a flag), busy is 0 and done is 0.
- R2: With no frame pending, every slot strobe carries the next bit of the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0), repeated without gaps.
- R3: dl_bit changes only at a clock edge where slot is high; with slot low it holds its value.
- R4: A frame is an opening flag, then buffer bytes from address 0 upward with each byte sent LSB first, then the check sequence, then a closing flag. The opening flag starts on the first slot after the idle flag in progress completes.
- R5: len_sel = 0 at start sends 76 buffer bytes; len_sel = 1 sends 82.
- R6: Between the flags, a 0 is inserted after every five consecutive 1s, and it takes up a slot like any other bit. This includes five 1s that end the check sequence just before the closing flag. The line never carries more than six 1s in a row.
- R7: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed in the order the bits are sent, preset to 0xFFFF and complemented. It covers the buffer bytes only and is sent CRC bit 0 first through bit 15, before stuffing.
- R8: busy rises in the cycle after an accepted start and stays high until the closing flag is sent. A start while busy is high is ignored.
- R9: Buffer writes while busy is high are ignored; a later frame sends the earlier content.
- R10: done is high for exactly one cycle, the cycle after the slot edge that carries the last closing-flag bit, and busy is low in that cycle.
- R11: A start given in the same cycle as the slot carrying bit 7 of an idle flag is accepted, and the opening flag follows on the very next slot. A buffer write in that same cycle is stored and sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 7 | Buffer byte address (0 to 87) |
| wr_data | input | 8 | Buffer byte value |
| len_sel | input | 1 | Message length at start: 0 = 76 bytes, 1 = 82 bytes |
| start | input | 1 | Request to send the buffered message |
| slot | input | 1 | Data-link bit slot strobe from the framer |
| dl_bit | output | 1 | Bit for the current slot |
| busy | output | 1 | Frame pending or in progress; buffer locked |
| done | output | 1 | One-cycle pulse after the closing flag |

## Verification
Two events can land in one clock edge: the host's start (together with a buffer write) and the slot that finishes an idle flag. A correct design must accept both and turn straight to the opening flag. The bench provokes this by counting idle slots since the last frame. It asserts start and a write to byte 0 on exactly the eighth slot. It then judges the result by requiring the captured stream from the next slot onward to match the expected frame bit for bit, with no extra idle flag in front, and to carry the newly written byte.

// File: rtl/dl_tx_pkg.sv
package dl_tx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE} tx_state_e;

  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = c >> 1;
    if (c[0] ^ b) n = n ^ CRC_POLY_REV;
    return n;
  endfunction
endpackage

// File: rtl/dl_msg_buf.sv
module dl_msg_buf #(
  parameter int DEPTH = 88,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dl_frame_seq.sv
module dl_frame_seq
  import dl_tx_pkg::*;
#(
  parameter int AW        = 7,
  parameter int LEN_SHORT = 76,
  parameter int LEN_LONG  = 82
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          len_sel,
  input  logic          slot,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          dl_bit,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] LAST_SHORT = AW'(LEN_SHORT - 1);
  localparam logic [AW-1:0] LAST_LONG  = AW'(LEN_LONG - 1);

  tx_state_e     state_q, state_nx;
  logic [2:0]    bit_q, bit_nx;
  logic [AW-1:0] byte_q, byte_nx;
  logic [2:0]    ones_q, ones_nx;
  logic [15:0]   crc_q, crc_nx;
  logic          pend_q, pend_nx;
  logic          len_q, len_nx;
  logic          done_q, done_nx;

  logic          start_ok, stuff, adv, cur_bit, in_body;
  logic [AW-1:0] last_byte;

  assign busy      = pend_q | (state_q != ST_IDLE);
  assign start_ok  = start & ~busy;
  assign in_body   = (state_q == ST_DATA) | (state_q == ST_FCS);
  assign stuff     = (in_body | (state_q == ST_CLOSE)) & (ones_q == 3'd5);
  assign adv       = slot & ~stuff;
  assign last_byte = len_q ? LAST_LONG : LAST_SHORT;
  assign rd_addr   = byte_q;

  always_comb begin
    unique case (state_q)
      ST_DATA: cur_bit = rd_data[bit_q];
      ST_FCS:  cur_bit = ~crc_q[{byte_q[0], bit_q}];
      default: cur_bit = FLAG_BYTE[bit_q];
    endcase
  end

  assign dl_bit = stuff ? 1'b0 : cur_bit;

  // next-state process
  always_comb begin
    state_nx = state_q;
    bit_nx   = bit_q;
    byte_nx  = byte_q;
    ones_nx  = ones_q;
    crc_nx   = crc_q;
    pend_nx  = pend_q | start_ok;
    len_nx   = start_ok ? len_sel : len_q;
    done_nx  = 1'b0;

    if (slot && stuff) ones_nx = 3'd0;

    if (adv) begin
      bit_nx  = bit_q + 3'd1;
      ones_nx = (in_body && cur_bit) ? ones_q + 3'd1 : 3'd0;
      if (state_q == ST_DATA) crc_nx = crc_step(crc_q, cur_bit);
      if (state_q == ST_OPEN) crc_nx = CRC_PRESET;
      if (bit_q == 3'd7) begin
        unique case (state_q)
          ST_IDLE: if (pend_q || start_ok) begin
            state_nx = ST_OPEN;
            pend_nx  = 1'b0;
          end
          ST_OPEN: begin
            state_nx = ST_DATA;
            byte_nx  = '0;
          end
          ST_DATA: begin
            if (byte_q == last_byte) begin
              state_nx = ST_FCS;
              byte_nx  = '0;
            end else begin
              byte_nx = byte_q + 1'b1;
            end
          end
          ST_FCS: begin
            if (byte_q[0]) state_nx = ST_CLOSE;
            else           byte_nx  = byte_q + 1'b1;
          end
          default: begin
            state_nx = ST_IDLE;
            done_nx  = 1'b1;
          end
        endcase
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      ones_q  <= '0;
      crc_q   <= CRC_PRESET;
      pend_q  <= 1'b0;
      len_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      bit_q   <= bit_nx;
      byte_q  <= byte_nx;
      ones_q  <= ones_nx;
      crc_q   <= crc_nx;
      pend_q  <= pend_nx;
      len_q   <= len_nx;
      done_q  <= done_nx;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/dl_msg_tx.sv
module dl_msg_tx #(
  parameter int DEPTH     = 88,
  parameter int LEN_SHORT = 76,
  parameter int LEN_LONG  = 82,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          len_sel,
  input  logic          start,
  input  logic          slot,
  output logic          dl_bit,
  output logic          busy,
  output logic          done
);
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          buf_we;

  assign buf_we = wr_en & ~busy & (32'(wr_addr) < DEPTH);

  dl_msg_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  dl_frame_seq #(.AW(AW), .LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_sel (len_sel),
    .slot    (slot),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .dl_bit  (dl_bit),
    .busy    (busy),
    .done    (done)
  );
endmodule

// File: rtl/dl_msg_tx_chk.sv
module dl_msg_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic slot,
  input logic start,
  input logic dl_bit,
  input logic busy,
  input logic done
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (slot && dl_bit)  run_q <= (run_q == 4'd15) ? run_q : run_q + 4'd1;
    else if (slot)            run_q <= '0;
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !slot |=> $stable(dl_bit));
  // R6
  ones_run_chk: assert property (@(posedge clk) disable iff (!rst_n) run_q <= 4'd6);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(slot));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

bind dl_msg_tx dl_msg_tx_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .slot   (slot),
  .start  (start),
  .dl_bit (dl_bit),
  .busy   (busy),
  .done   (done)
);

// File: tb/tb_dl_msg_tx.sv
module tb_dl_msg_tx;
  logic       clk, rst_n, wr_en, len_sel, start, slot;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       dl_bit, busy, done;

  dl_msg_tx dut (.*);

  int n_tests, n_fail, ncap, exp_n;
  bit cap [4096];
  bit exp_b [2048];
  logic [7:0] mem_ref [88];
  logic done_s, done_late, finished;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input bit b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input int len);
    logic [15:0] crc;
    logic [15:0] fcs;
    int ones;
    bit b;
    exp_n = 0;
    crc = 16'hFFFF;
    ones = 0;
    for (int i = 0; i < 8; i++) push(8'h7E >> i);
    for (int k = 0; k < len * 8 + 16; k++) begin
      if (k < len * 8) begin
        b = mem_ref[k / 8][k % 8];
        crc = (crc[0] ^ b) ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
        fcs = ~crc;
      end else begin
        b = fcs[k - len * 8];
      end
      if (ones == 5) begin push(1'b0); ones = 0; end
      push(b);
      ones = b ? ones + 1 : 0;
    end
    if (ones == 5) push(1'b0);
    for (int i = 0; i < 8; i++) push(8'h7E >> i);
  endtask

  task automatic do_slot(input bit st, input bit w, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    slot = 1'b1;
    if (st) start = 1'b1;
    if (w) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    #1 cap[ncap] = dl_bit;
    ncap++;
    @(negedge clk);
    slot = 1'b0; start = 1'b0; wr_en = 1'b0;
    done_s = done;
    @(negedge clk);
    done_late = done;
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mem_ref[a] = d;
  endtask

  task automatic compare_tail(input string req);
    int bad;
    int first;
    bad = 0;
    first = -1;
    if (ncap < exp_n) bad = 1;
    else
      for (int i = 0; i < exp_n; i++)
        if (cap[ncap - exp_n + i] != exp_b[i]) begin
          bad++;
          if (first < 0) first = i;
        end
    chk(bad == 0, req, first, exp_n);
  endtask

  // sends a frame; disturb_at >= 0 puts a write and a start on that slot
  task automatic run_msg(input bit lsel, input int disturb_at, input string req);
    bit got;
    bit busy_bad;
    bit pulse_bad;
    build_exp(lsel ? 82 : 76);
    @(negedge clk);
    start = 1'b1; len_sel = lsel;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    ncap = 0; got = 0; busy_bad = 0; pulse_bad = 0;
    while (!got && ncap < 4000) begin
      do_slot(ncap == disturb_at, ncap == disturb_at, 7'd0, 8'h00);
      got = done_s;
      if (!got && !busy) busy_bad = 1;
      if (got && done_late) pulse_bad = 1;
    end
    chk(got, "R10 done seen", got, 1);
    chk(!pulse_bad, "R10 done one cycle", pulse_bad, 0);
    chk(!busy_bad, "R8 busy during frame", busy_bad, 0);
    chk(busy == 1'b0, "R10 busy low after done", busy, 0);
    compare_tail(req);
  endtask

  task automatic t_reset();
    #1;
    chk(dl_bit == 1'b0, "R1 dl_bit", dl_bit, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_idle();
    int bad;
    bad = 0;
    ncap = 0;
    for (int i = 0; i < 24; i++) begin
      do_slot(0, 0, 7'd0, 8'h00);
      if (cap[i] != ((8'h7E >> (i % 8)) & 1)) bad++;
    end
    chk(bad == 0, "R2 idle flags", bad, 0);
  endtask

  task automatic t_hold();
    int bad;
    bad = 0;
    do_slot(0, 0, 7'd0, 8'h00);
    do_slot(0, 0, 7'd0, 8'h00);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dl_bit != 1'b1) bad++;
    end
    chk(bad == 0, "R3 hold without slot", bad, 0);
    for (int i = 0; i < 6; i++) do_slot(0, 0, 7'd0, 8'h00);
  endtask

  task automatic t_msg76();
    for (int i = 0; i < 88; i++) wr_byte(7'(i), 8'(i * 37 + 5));
    run_msg(1'b0, -1, "R4 R5 R7 short frame");
  endtask

  task automatic t_msg82_stuff();
    int bad;
    for (int i = 0; i < 88; i++) wr_byte(7'(i), 8'hFF);
    run_msg(1'b1, 40, "R5 R6 R7 long all-ones frame");
    bad = 0;
    ncap = 0;
    for (int i = 0; i < 24; i++) begin
      do_slot(0, 0, 7'd0, 8'h00);
      if (cap[i] != ((8'h7E >> (i % 8)) & 1)) bad++;
      if (busy) bad++;
    end
    chk(bad == 0, "R8 start while busy ignored", bad, 0);
  endtask

  task automatic t_repeat();
    run_msg(1'b1, -1, "R9 write while busy ignored");
  endtask

  task automatic t_coincide();
    bit got;
    ncap = 0;
    for (int i = 0; i < 7; i++) do_slot(0, 0, 7'd0, 8'h00);
    mem_ref[0] = 8'hA5;
    build_exp(76);
    len_sel = 1'b0;
    do_slot(1, 1, 7'd0, 8'hA5);
    chk(busy == 1'b1, "R11 busy after edge start", busy, 1);
    ncap = 0;
    got = 0;
    while (!got && ncap < 4000) begin
      do_slot(0, 0, 7'd0, 8'h00);
      got = done_s;
    end
    chk(ncap == exp_n, "R11 frame length from next slot", ncap, exp_n);
    compare_tail("R11 frame content");
  endtask

  initial begin
    finished = 1'b0;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    len_sel = 1'b0; start = 1'b0; slot = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_hold();
    t_msg76();
    t_msg82_stuff();
    t_repeat();
    t_coincide();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule